// File: doc/BRIEF.md
# Video Standard Detector with Host Override

This block watches a 10-bit digital video word stream, one word per clock, and works out which of eight 525/625-line standards is arriving. It measures two things between timing reference sequences: the number of words from one end-of-active-video marker to the next, and the number of lines between rising edges of the field bit. The line count picks the 525-line or 625-line family. The word count picks one of four sampling structures within that family. A format bit, which separates RGB from YCbCr, is taken from an identification word in the stream.

A measured standard reaches the read-side outputs only after the same result has been seen on a set number of consecutive lines. This stops brief corruption from changing what is reported. A stream that matches nothing leaves the last reported standard in place and raises a not-locked flag.

A host write port holds a manual register. When its manual bit is set, the host's code and format bit replace the detected ones on the outputs. Detection keeps running in the background.

Top module: `vid_std_detect`

## Requirements
- R1: Reset (asynchronous, active low) gives stdCode 0000, fmtBit 0, notLocked 1 and the manual register cleared.
- R2: Bit 2 of the standard code is 1 for the 625-line family and 0 for the 525-line family. Bits 1:0 give the structure: 00 is 4:2:2 at 13.5 MHz, 01 is composite, 10 is 16x9 4:2:2 at 18 MHz, 11 is 4:4:4:4 single link. The default nominal line lengths in words are 1716, 910, 2288 and 3432 for codes 0 to 3, and 1728, 1135, 2304 and 3456 for codes 4 to 7. All of them are parameters.
- R3: An EAV is the words 3FF, 000, 000 followed by a word with bit 9 = 1 and bit 6 = 1. Bit 8 of that word is the field bit. The line length is the word distance between successive EAVs. The frame length is the number of EAVs between two field-bit rises, and it must equal LINES_525 or LINES_625.
- R4: A new code (with its format bit) is reported only after PERSIST consecutive valid measurements give the same result. It appears two clocks after the EAV that completes the run.
- R5: A measurement that differs from the previous candidate restarts the count at one. An invalid measurement restarts the count from zero.
- R6: An invalid measurement leaves stdCode and fmtBit unchanged and sets notLocked. notLocked is cleared when a code is committed.
- R7: If MAX_WORDS words pass with no EAV, the block counts this as an invalid measurement and forgets the frame measurement.
- R8: An identification word is 3FF, 000, 000 followed by a word with bit 9 = 0. Its bit 4 is the format bit (1 = RGB). A detected format bit is reported only for codes whose bits 1:0 are 11. For all other codes it is 0.
- R9: hostWrData is {manual(5), format(4), code(3:0)}. From the clock after a write with manual = 1, stdCode and fmtBit show the written values. After a write with manual = 0, they show the detected values again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rstN | input | 1 | Asynchronous active-low reset |
| vidWord | input | 10 | Video word, one per clock |
| hostWrEn | input | 1 | Host write strobe for the manual register |
| hostWrData | input | 6 | {manual, format, code[3:0]} |
| stdCode | output | 4 | Reported standard code |
| fmtBit | output | 1 | Reported format bit (1 = RGB) |
| notLocked | output | 1 | Stream not recognised since the last commit |

## Verification
A detection result appears two clocks after the EAV that completes a persistence run: one register holds the measurement strobe and one holds the committed code. The bench checks only after whole lines have been sent, and every line is at least eight words long, so the commit has always settled by the time the check runs. Persistence is checked at line granularity. The bench counts which EAV measures which line, and checks one line before and one line after the commit is due. A host write shows on the outputs in the clock after the write, and the bench samples at the next falling edge.

// File: rtl/vsd_pkg.sv
package vsd_pkg;
  // one measurement result, pulsed by the datapath once per line end or timeout
  typedef struct packed {
    logic       strobe;
    logic       valid;
    logic [3:0] code;
    logic       fmt;
  } meas_t;

  // host manual register layout
  typedef struct packed {
    logic       manual;
    logic       fmt;
    logic [3:0] code;
  } host_t;
endpackage

// File: rtl/vsd_trs_parser.sv
module vsd_trs_parser (
  input  logic       clk,
  input  logic       rstN,
  input  logic [9:0] vidWord,
  output logic       eavHit,
  output logic       idHit,
  output logic       fieldBit,
  output logic       idFmt
);
  logic [9:0] hist1, hist2, hist3;
  logic       preamble;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist1 <= '0;
      hist2 <= '0;
      hist3 <= '0;
    end else begin
      hist3 <= hist2;
      hist2 <= hist1;
      hist1 <= vidWord;
    end
  end

  assign preamble = (hist3 == 10'h3FF) && (hist2 == 10'h000) && (hist1 == 10'h000);
  assign eavHit   = preamble && vidWord[9] && vidWord[6];
  assign idHit    = preamble && !vidWord[9];
  assign fieldBit = vidWord[8];
  assign idFmt    = vidWord[4];
endmodule

// File: rtl/vsd_datapath.sv
module vsd_datapath
  import vsd_pkg::*;
#(
  parameter logic [127:0] LINE_WORDS = {16'd3456, 16'd2304, 16'd1135, 16'd1728,
                                        16'd3432, 16'd2288, 16'd910,  16'd1716},
  parameter int LINES_525 = 525,
  parameter int LINES_625 = 625,
  parameter int MAX_WORDS = 4095
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [9:0] vidWord,
  output meas_t      measOut
);
  localparam int WORD_W   = $clog2(MAX_WORDS + 1);
  localparam int LINE_MAX = ((LINES_525 > LINES_625) ? LINES_525 : LINES_625) + 1;
  localparam int LINE_W   = $clog2(LINE_MAX + 1);
  localparam int NUM_STD  = 8;

  logic              eavHit, idHit, fieldBit, idFmt;
  logic [WORD_W-1:0] wordCnt;
  logic              eavSeen;
  logic [LINE_W-1:0] lineCnt;
  logic              prevF, riseSeen, famValid, famPal, idFmtReg;
  logic [NUM_STD-1:0] matchVec;
  logic [3:0]        famMatch;
  logic [1:0]        subIdx;
  logic              candValid, candFmt, timeout, newFrame, is525, is625;

  vsd_trs_parser uParser (
    .clk      (clk),
    .rstN     (rstN),
    .vidWord  (vidWord),
    .eavHit   (eavHit),
    .idHit    (idHit),
    .fieldBit (fieldBit),
    .idFmt    (idFmt)
  );

  // one comparator per standard against its nominal line length
  for (genvar gi = 0; gi < NUM_STD; gi++) begin : gMatch
    assign matchVec[gi] = (int'(wordCnt) == int'(LINE_WORDS[gi*16 +: 16]));
  end

  always_comb begin
    famMatch = famPal ? matchVec[7:4] : matchVec[3:0];
    subIdx   = 2'd0;
    for (int k = 3; k >= 0; k--) begin
      if (famMatch[k]) subIdx = 2'(k);
    end
  end

  assign candValid = famValid && (|famMatch);
  assign candFmt   = (subIdx == 2'b11) && idFmtReg;
  assign timeout   = !eavHit && (wordCnt == WORD_W'(MAX_WORDS - 1));
  assign newFrame  = eavHit && fieldBit && !prevF;
  assign is525     = (int'(lineCnt) == LINES_525);
  assign is625     = (int'(lineCnt) == LINES_625);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordCnt  <= '0;
      eavSeen  <= 1'b0;
      lineCnt  <= '0;
      prevF    <= 1'b0;
      riseSeen <= 1'b0;
      famValid <= 1'b0;
      famPal   <= 1'b0;
      idFmtReg <= 1'b0;
      measOut  <= '0;
    end else begin
      measOut <= '0;
      if (idHit) idFmtReg <= idFmt;
      if (eavHit) begin
        wordCnt <= WORD_W'(1);
        eavSeen <= 1'b1;
        prevF   <= fieldBit;
        if (eavSeen) begin
          measOut.strobe <= 1'b1;
          measOut.valid  <= candValid;
          measOut.code   <= {famPal, subIdx};
          measOut.fmt    <= candFmt;
        end
        if (newFrame) begin
          lineCnt  <= LINE_W'(1);
          riseSeen <= 1'b1;
          if (riseSeen) begin
            famValid <= is525 || is625;
            famPal   <= is625;
          end
        end else if (lineCnt != LINE_W'(LINE_MAX)) begin
          lineCnt <= lineCnt + LINE_W'(1);
        end
      end else begin
        if (wordCnt != WORD_W'(MAX_WORDS)) wordCnt <= wordCnt + WORD_W'(1);
        if (timeout) begin
          measOut.strobe <= 1'b1;
          measOut.valid  <= 1'b0;
          eavSeen        <= 1'b0;
          riseSeen       <= 1'b0;
          famValid       <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/vsd_control.sv
module vsd_control
  import vsd_pkg::*;
#(
  parameter int PERSIST = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  meas_t      meas,
  input  logic       hostWrEn,
  input  host_t      hostWr,
  output logic [3:0] detCode,
  output logic       detFmt,
  output logic       notLocked,
  output host_t      hostReg
);
  localparam int CNT_W = $clog2(PERSIST + 1);

  logic [4:0]       candReg;
  logic [CNT_W-1:0] persistCnt, nextCnt;
  logic             sameCand;

  always_comb begin
    sameCand = (persistCnt != '0) && ({meas.fmt, meas.code} == candReg);
    if (!sameCand)                          nextCnt = CNT_W'(1);
    else if (persistCnt == CNT_W'(PERSIST)) nextCnt = persistCnt;
    else                                    nextCnt = persistCnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      candReg    <= '0;
      persistCnt <= '0;
      detCode    <= 4'b0000;
      detFmt     <= 1'b0;
      notLocked  <= 1'b1;
      hostReg    <= '0;
    end else begin
      if (hostWrEn) hostReg <= hostWr;
      if (meas.strobe) begin
        if (!meas.valid) begin
          persistCnt <= '0;
          notLocked  <= 1'b1;
        end else begin
          candReg    <= {meas.fmt, meas.code};
          persistCnt <= nextCnt;
          if (nextCnt == CNT_W'(PERSIST)) begin
            detCode   <= meas.code;
            detFmt    <= meas.fmt;
            notLocked <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/vid_std_detect.sv
module vid_std_detect
  import vsd_pkg::*;
#(
  parameter logic [127:0] LINE_WORDS = {16'd3456, 16'd2304, 16'd1135, 16'd1728,
                                        16'd3432, 16'd2288, 16'd910,  16'd1716},
  parameter int LINES_525 = 525,
  parameter int LINES_625 = 625,
  parameter int MAX_WORDS = 4095,
  parameter int PERSIST   = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [9:0] vidWord,
  input  logic       hostWrEn,
  input  logic [5:0] hostWrData,
  output logic [3:0] stdCode,
  output logic       fmtBit,
  output logic       notLocked
);
  meas_t      measBus;
  host_t      hostReg;
  logic [3:0] detCode;
  logic       detFmt;

  vsd_datapath #(
    .LINE_WORDS (LINE_WORDS),
    .LINES_525  (LINES_525),
    .LINES_625  (LINES_625),
    .MAX_WORDS  (MAX_WORDS)
  ) uDatapath (
    .clk     (clk),
    .rstN    (rstN),
    .vidWord (vidWord),
    .measOut (measBus)
  );

  vsd_control #(.PERSIST(PERSIST)) uControl (
    .clk       (clk),
    .rstN      (rstN),
    .meas      (measBus),
    .hostWrEn  (hostWrEn),
    .hostWr    (host_t'(hostWrData)),
    .detCode   (detCode),
    .detFmt    (detFmt),
    .notLocked (notLocked),
    .hostReg   (hostReg)
  );

  assign stdCode = hostReg.manual ? hostReg.code : detCode;
  assign fmtBit  = hostReg.manual ? hostReg.fmt  : detFmt;
endmodule

// File: rtl/vsd_checker.sv
module vsd_checker (
  input logic       clk,
  input logic       rstN,
  input logic       hostWrEn,
  input logic [5:0] hostWrData,
  input logic [3:0] stdCode,
  input logic       fmtBit,
  input logic       notLocked,
  input logic       measStrobe,
  input logic       measValid,
  input logic [3:0] detCode,
  input logic       manualOn
);
  AST_MANUAL_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostWrData[5]) |=>
      (stdCode == $past(hostWrData[3:0]) && fmtBit == $past(hostWrData[4]))); // R9

  AST_CODE_ONLY_ON_MEAS: assert property (@(posedge clk) disable iff (!rstN)
    (detCode != $past(detCode)) |-> $past(measStrobe && measValid)); // R4

  AST_FMT_SINGLE_LINK: assert property (@(posedge clk) disable iff (!rstN)
    (!manualOn && stdCode[1:0] != 2'b11) |-> !fmtBit); // R8

  AST_LOCK_ON_VALID: assert property (@(posedge clk) disable iff (!rstN)
    $fell(notLocked) |-> $past(measStrobe && measValid)); // R6

  AST_INVALID_SETS_NOLOCK: assert property (@(posedge clk) disable iff (!rstN)
    (measStrobe && !measValid) |=> (notLocked && $stable(detCode))); // R6
endmodule

bind vid_std_detect vsd_checker uChk (
  .clk        (clk),
  .rstN       (rstN),
  .hostWrEn   (hostWrEn),
  .hostWrData (hostWrData),
  .stdCode    (stdCode),
  .fmtBit     (fmtBit),
  .notLocked  (notLocked),
  .measStrobe (measBus.strobe),
  .measValid  (measBus.valid),
  .detCode    (detCode),
  .manualOn   (hostReg.manual)
);

// File: tb/vid_std_detect_test.sv
module vid_std_detect_test;
  localparam int CLK_PERIOD = 10;
  localparam int P_T        = 4;
  localparam int L525_T     = 5;
  localparam int L625_T     = 7;
  localparam int MAXW_T     = 127;
  localparam logic [127:0] WORDS_T = {16'd68, 16'd60, 16'd52, 16'd44,
                                      16'd64, 16'd56, 16'd48, 16'd40};

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [9:0] vidWord = 10'h200;
  logic       hostWrEn = 1'b0;
  logic [5:0] hostWrData = '0;
  logic [3:0] stdCode;
  logic       fmtBit;
  logic       notLocked;

  int testsRun = 0;
  int testsFailed = 0;
  int curLine = 0;
  int frameLines = L525_T;
  int curWords = 40;
  logic curFmt = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vid_std_detect #(
    .LINE_WORDS (WORDS_T),
    .LINES_525  (L525_T),
    .LINES_625  (L625_T),
    .MAX_WORDS  (MAXW_T),
    .PERSIST    (P_T)
  ) uut (
    .clk        (clk),
    .rstN       (rstN),
    .vidWord    (vidWord),
    .hostWrEn   (hostWrEn),
    .hostWrData (hostWrData),
    .stdCode    (stdCode),
    .fmtBit     (fmtBit),
    .notLocked  (notLocked)
  );

  function automatic int wordsFor(int code);
    int table8 [8] = '{40, 48, 56, 64, 44, 52, 60, 68};
    return table8[code & 7];
  endfunction

  function automatic int linesFor(int code);
    return ((code & 4) != 0) ? L625_T : L525_T;
  endfunction

  function automatic int expFmt(int code, int fmt);
    return ((code & 3) == 3) ? fmt : 0;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic putWord(logic [9:0] w);
    @(negedge clk);
    vidWord = w;
  endtask

  task automatic putFiller();
    putWord(10'h010 + 10'($urandom % 32'h3D0));
  endtask

  task automatic sendLine(int words, logic f, logic fmt);
    putWord(10'h3FF); putWord(10'h000); putWord(10'h000);
    putWord({1'b1, f, 8'h40});
    putWord(10'h3FF); putWord(10'h000); putWord(10'h000);
    putWord({1'b0, 4'b0000, fmt, 4'b0000});
    for (int i = 8; i < words; i++) putFiller();
  endtask

  task automatic sendStd();
    sendLine(curWords, (curLine >= frameLines / 2), curFmt);
    curLine = (curLine + 1) % frameLines;
  endtask

  task automatic selectStd(int code, logic fmt);
    curWords   = wordsFor(code);
    frameLines = linesFor(code);
    curLine    = 0;
    curFmt     = fmt;
  endtask

  task automatic settle();
    repeat (3 * frameLines + P_T + 2) sendStd();
  endtask

  task automatic hostWrite(logic [5:0] d);
    @(negedge clk);
    hostWrEn = 1'b1;
    hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    testsFailed++;
    $display("FAIL watchdog (all requirements): actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset defaults
    check("R1", "stdCode in reset", int'(stdCode), 0);
    check("R1", "fmtBit in reset", int'(fmtBit), 0);
    check("R1", "notLocked in reset", int'(notLocked), 1);
    rstN = 1'b1;
    repeat (2) putFiller();
    check("R1", "stdCode after release", int'(stdCode), 0);

    // R2 R3 R8 R6: random standards
    for (int it = 0; it < 10; it++) begin
      int code = int'($urandom % 8);
      logic fmt = 1'($urandom % 2);
      selectStd(code, fmt);
      settle();
      check("R2", "random detected code", int'(stdCode), code);
      check("R8", "random format bit", int'(fmtBit), expFmt(code, int'(fmt)));
      check("R6", "random lock", int'(notLocked), 0);
    end

    // R8 directed format cases
    selectStd(7, 1'b1); settle();
    check("R8", "pal single link rgb code", int'(stdCode), 7);
    check("R8", "pal single link rgb fmt", int'(fmtBit), 1);
    selectStd(6, 1'b1); settle();
    check("R8", "fmt masked on 16x9", int'(fmtBit), 0);
    check("R3", "pal 16x9 code", int'(stdCode), 6);

    // R4 R5 persistence with an interrupting bad line
    selectStd(1, 1'b0); settle();
    check("R2", "ntsc composite code", int'(stdCode), 1);
    curWords = wordsFor(2);
    repeat (P_T - 1) sendStd();
    curWords = 30;
    sendStd();
    curWords = wordsFor(2);
    repeat (P_T) sendStd();
    check("R5", "restart keeps old code", int'(stdCode), 1);
    check("R6", "bad line sets notLocked", int'(notLocked), 1);
    sendStd();
    check("R4", "commit after persist run", int'(stdCode), 2);
    check("R6", "commit clears notLocked", int'(notLocked), 0);

    // R6 unrecognised lines
    curWords = 30;
    repeat (P_T + 2) sendStd();
    check("R6", "unknown keeps code", int'(stdCode), 2);
    check("R6", "unknown notLocked", int'(notLocked), 1);
    curWords = wordsFor(2);
    repeat (P_T + 2) sendStd();
    check("R6", "relock notLocked", int'(notLocked), 0);

    // R7 no EAV timeout
    repeat (MAXW_T + 13) putFiller();
    check("R7", "timeout notLocked", int'(notLocked), 1);
    check("R7", "timeout keeps code", int'(stdCode), 2);
    selectStd(2, 1'b0); settle();
    check("R7", "recovery after timeout", int'(notLocked), 0);

    // R9 manual override
    hostWrite(6'b1_1_0111);
    check("R9", "manual code", int'(stdCode), 7);
    check("R9", "manual fmt", int'(fmtBit), 1);
    repeat (P_T + 2) sendStd();
    check("R9", "manual holds during detection", int'(stdCode), 7);
    hostWrite(6'b1_1_0001);
    check("R9", "manual fmt on composite", int'(fmtBit), 1);
    hostWrite(6'b0_0_0000);
    check("R9", "manual cleared shows detected", int'(stdCode), 2);
    check("R9", "manual cleared fmt", int'(fmtBit), 0);

    // R1 reset mid-run
    selectStd(5, 1'b0); settle();
    check("R2", "pal composite code", int'(stdCode), 5);
    hostWrite(6'b1_0_0011);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    check("R1", "mid reset code", int'(stdCode), 0);
    check("R1", "mid reset notLocked", int'(notLocked), 1);
    check("R1", "mid reset fmt", int'(fmtBit), 0);
    rstN = 1'b1;

    summary();
    $finish;
  end
endmodule